// File: doc/BRIEF.md
# Receive Frame Status Trailer Appender

This block sits at the tail of an Ethernet receive path, between the MAC core and a downstream byte-stream sink. The MAC hands it one byte per cycle, with start-of-frame and end-of-frame markers. On the end-of-frame byte it also gives three error indications: collision seen, framing (alignment) error and bad frame check sequence. The MAC cannot be stalled. Bytes therefore go into a data FIFO, and the egress side forwards them to the sink under a valid/ready handshake as soon as they arrive (cut-through).

When a frame ends, the block builds a four-byte status trailer and queues it in a small status FIFO. The trailer goes out directly after the frame's last forwarded byte. It packs:
- the received byte count, which includes the checksum bytes because nothing is stripped;
- four error flags;
- the current values of two 8-bit statistics counters: frames shorter than 64 bytes, and frames that saw a collision.

Each counter wraps past 255 and raises a one-cycle pulse when it does. Downstream logic uses the count to reject frames too short to hold a header plus checksum (under 18 bytes).

The egress sequencer has five states:
- `ST_BODY` forwards data bytes. It moves to `ST_TRL0` once the status of the frame in flight is queued and every stored byte of that frame has been sent.
- `ST_TRL0`, `ST_TRL1`, `ST_TRL2` and `ST_TRL3` each present one trailer byte. Each advances on an accepted handshake.
- `ST_TRL3` returns to `ST_BODY` and releases the status entry.

Top module: `rx_status_trailer`

## Requirements
- R1: Each frame that is not ignored leaves the output as its stored data bytes in arrival order, followed by exactly four trailer bytes. `out_last` is high on the fourth trailer byte only.
- R2: Trailer byte 0 is bits 7..0 of the frame's received byte count. Bits 3..0 of trailer byte 1 are count bits 11..8. The count covers every byte from the start-of-frame byte through the end-of-frame byte, checksum bytes included.
- R3: For frames of 4095 bytes or more the count field reads 4095 (0xFFF).
- R4: Trailer byte 1 carries four flags. Bit 7 is overflow (R9). Bits 6, 5 and 4 are `in_coll`, `in_frame_err` and `in_fcs_err`, sampled on the end-of-frame byte.
- R5: A frame whose received count is below 64 increments an 8-bit wrapping short-frame counter. Trailer byte 2 is that counter's value after this frame's update. The counter is zero after reset.
- R6: A frame whose end-of-frame byte has `in_coll` high increments an 8-bit wrapping collision counter. Trailer byte 3 is that counter's value after this frame's update. The counter is zero after reset.
- R7: `runt_wrap` and `coll_wrap` are each high for exactly one cycle, the cycle after the end-of-frame byte that moves the corresponding counter from 255 to 0. They are low at all other times.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. No byte is lost or repeated.
- R9: A byte that arrives while the data FIFO is full is dropped, and that frame's overflow flag (byte 1 bit 7) is set. The frame's stored bytes and its trailer are still emitted, and the count still covers every received byte.
- R10: A frame whose start-of-frame byte arrives while the status FIFO is full is ignored entirely. None of its bytes are emitted, it gets no trailer, and both counters stay unchanged.
- R11: Bytes that arrive with `in_valid` high outside a frame (no start-of-frame seen since the last end-of-frame) are ignored.
- R12: After reset `out_valid`, `runt_wrap` and `coll_wrap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_coll | input | 1 | Collision seen; sampled on the end-of-frame byte |
| in_frame_err | input | 1 | Framing error; sampled on the end-of-frame byte |
| in_fcs_err | input | 1 | Bad checksum; sampled on the end-of-frame byte |
| out_valid | output | 1 | Output byte offered |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the last trailer byte |
| out_ready | input | 1 | Sink accepts the offered byte |
| runt_wrap | output | 1 | One-cycle pulse when the short-frame counter wraps |
| coll_wrap | output | 1 | One-cycle pulse when the collision counter wraps |

## Verification
The bench builds the block with a 16-byte data FIFO and a 4-entry status FIFO. With those sizes a single 20-byte frame sent with the sink held off overflows deterministically. Five two-byte frames sent with the sink held off fill the status queue and force the fifth to be ignored. A sweep over every frame length from 1 to 70 covers the 63/64 short-frame boundary with every flag combination. More than 256 short colliding frames drive both counters through a wrap, and frames of 4095, 4096 and 4100 bytes reach count saturation within the cycle budget.

// File: rtl/rxtrl_pkg.sv
package rxtrl_pkg;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 12;
    localparam int STORE_W    = 16;
    localparam int RUNT_LIMIT = 64;

    typedef enum logic [2:0] {
        ST_BODY,
        ST_TRL0,
        ST_TRL1,
        ST_TRL2,
        ST_TRL3
    } egr_state_t;

    typedef struct packed {
        logic [STORE_W-1:0] stored;
        logic [BYTE_W-1:0]  b3;
        logic [BYTE_W-1:0]  b2;
        logic [BYTE_W-1:0]  b1;
        logic [BYTE_W-1:0]  b0;
    } stat_t;
endpackage

// File: rtl/rxtrl_fifo.sv
module rxtrl_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    fill;
    logic             do_push, do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            fill <= fill + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/rxtrl_ingest.sv
module rxtrl_ingest
    import rxtrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_coll,
    input  logic              in_frame_err,
    input  logic              in_fcs_err,
    input  logic              data_full,
    input  logic              stat_full,
    output logic              data_push,
    output logic [BYTE_W-1:0] data_wdata,
    output logic              stat_push,
    output stat_t             stat_wdata,
    output logic              runt_wrap,
    output logic              coll_wrap
);
    localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
    localparam logic [BYTE_W-1:0] CTR_MAX = {BYTE_W{1'b1}};

    logic               in_frame, drop_frame, ovf;
    logic [CNT_W-1:0]   rx_cnt, cnt_now;
    logic [STORE_W-1:0] st_cnt, st_now;
    logic [BYTE_W-1:0]  runt_cnt, coll_cnt, runt_nx, coll_nx;
    logic               dropping, keep, ovf_now, runt_inc, commit;

    always_comb begin
        dropping   = in_sof ? stat_full : drop_frame;
        keep       = in_valid && !dropping && (in_sof || in_frame);
        data_push  = keep && !data_full;
        data_wdata = in_data;
        cnt_now    = in_sof ? CNT_W'(1) : ((rx_cnt == CNT_MAX) ? CNT_MAX : rx_cnt + 1'b1);
        st_now     = (in_sof ? '0 : st_cnt) + STORE_W'(data_push);
        ovf_now    = (in_sof ? 1'b0 : ovf) | (keep && data_full);
        runt_inc   = (cnt_now < CNT_W'(RUNT_LIMIT));
        runt_nx    = runt_cnt + BYTE_W'(runt_inc);
        coll_nx    = coll_cnt + BYTE_W'(in_coll);
        commit     = keep && in_eof;
        stat_push  = commit;
        stat_wdata.stored = st_now;
        stat_wdata.b0     = cnt_now[7:0];
        stat_wdata.b1     = {ovf_now, in_coll, in_frame_err, in_fcs_err, cnt_now[11:8]};
        stat_wdata.b2     = runt_nx;
        stat_wdata.b3     = coll_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame   <= 1'b0;
            drop_frame <= 1'b0;
            rx_cnt     <= '0;
            st_cnt     <= '0;
            ovf        <= 1'b0;
            runt_cnt   <= '0;
            coll_cnt   <= '0;
            runt_wrap  <= 1'b0;
            coll_wrap  <= 1'b0;
        end else begin
            runt_wrap <= 1'b0;
            coll_wrap <= 1'b0;
            if (in_valid) begin
                if (in_sof) begin
                    in_frame   <= !in_eof;
                    drop_frame <= stat_full;
                end else if (in_eof) begin
                    in_frame <= 1'b0;
                end
            end
            if (keep) begin
                rx_cnt <= cnt_now;
                st_cnt <= st_now;
                ovf    <= ovf_now;
            end
            if (commit) begin
                runt_cnt  <= runt_nx;
                coll_cnt  <= coll_nx;
                runt_wrap <= runt_inc && (runt_cnt == CTR_MAX);
                coll_wrap <= in_coll && (coll_cnt == CTR_MAX);
            end
        end
    end
endmodule

// File: rtl/rxtrl_egress.sv
module rxtrl_egress
    import rxtrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_empty,
    input  logic [BYTE_W-1:0] data_q,
    input  logic              stat_empty,
    input  stat_t             stat_q,
    output logic              data_pop,
    output logic              stat_pop,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready
);
    egr_state_t         state, state_nx;
    logic [STORE_W-1:0] sent;
    logic               frame_done;

    assign frame_done = !stat_empty && (sent == stat_q.stored);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_BODY;
            sent  <= '0;
        end else begin
            state <= state_nx;
            if (stat_pop)      sent <= '0;
            else if (data_pop) sent <= sent + 1'b1;
        end
    end

    always_comb begin
        state_nx  = state;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        data_pop  = 1'b0;
        stat_pop  = 1'b0;
        unique case (state)
            ST_BODY: begin
                if (frame_done) begin
                    state_nx = ST_TRL0;
                end else begin
                    out_valid = !data_empty;
                    out_data  = data_q;
                    data_pop  = !data_empty && out_ready;
                end
            end
            ST_TRL0: begin
                out_valid = 1'b1;
                out_data  = stat_q.b0;
                if (out_ready) state_nx = ST_TRL1;
            end
            ST_TRL1: begin
                out_valid = 1'b1;
                out_data  = stat_q.b1;
                if (out_ready) state_nx = ST_TRL2;
            end
            ST_TRL2: begin
                out_valid = 1'b1;
                out_data  = stat_q.b2;
                if (out_ready) state_nx = ST_TRL3;
            end
            ST_TRL3: begin
                out_valid = 1'b1;
                out_data  = stat_q.b3;
                out_last  = 1'b1;
                if (out_ready) begin
                    state_nx = ST_BODY;
                    stat_pop = 1'b1;
                end
            end
            default: state_nx = ST_BODY;
        endcase
    end
endmodule

// File: rtl/rx_status_trailer.sv
module rx_status_trailer
    import rxtrl_pkg::*;
#(
    parameter int DATA_DEPTH = 16,
    parameter int STAT_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_coll,
    input  logic              in_frame_err,
    input  logic              in_fcs_err,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              runt_wrap,
    output logic              coll_wrap
);
    localparam int STAT_W = $bits(stat_t);

    logic              data_push, data_pop, data_empty, data_full;
    logic [BYTE_W-1:0] data_wdata, data_q;
    logic              stat_push, stat_pop, stat_empty, stat_full;
    stat_t             stat_wdata, stat_q;
    logic [STAT_W-1:0] stat_q_raw;

    assign stat_q = stat_t'(stat_q_raw);

    rxtrl_ingest u_ingest (
        .clk, .rst, .in_valid, .in_data, .in_sof, .in_eof,
        .in_coll, .in_frame_err, .in_fcs_err,
        .data_full, .stat_full, .data_push, .data_wdata,
        .stat_push, .stat_wdata, .runt_wrap, .coll_wrap
    );

    rxtrl_fifo #(.WIDTH(BYTE_W), .DEPTH(DATA_DEPTH)) u_data_fifo (
        .clk, .rst, .push(data_push), .wdata(data_wdata), .pop(data_pop),
        .rdata(data_q), .empty(data_empty), .full(data_full)
    );

    rxtrl_fifo #(.WIDTH(STAT_W), .DEPTH(STAT_DEPTH)) u_stat_fifo (
        .clk, .rst, .push(stat_push), .wdata(STAT_W'(stat_wdata)), .pop(stat_pop),
        .rdata(stat_q_raw), .empty(stat_empty), .full(stat_full)
    );

    rxtrl_egress u_egress (
        .clk, .rst, .data_empty, .data_q, .stat_empty, .stat_q,
        .data_pop, .stat_pop, .out_valid, .out_data, .out_last, .out_ready
    );
endmodule

// File: rtl/rx_status_trailer_chk.sv
module rx_status_trailer_chk (
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       runt_wrap,
    input logic       coll_wrap
);
    // R8: an offered byte that is not taken stays on the port unchanged
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R1: after the final trailer byte is taken, the next cycle is not a final trailer byte
    a_r1_last_then_body: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_last);

    // R7: short-frame wrap pulse lasts one cycle
    a_r7_runt_pulse_single: assert property (@(posedge clk) disable iff (rst)
        runt_wrap |=> !runt_wrap);

    // R7: collision wrap pulse lasts one cycle
    a_r7_coll_pulse_single: assert property (@(posedge clk) disable iff (rst)
        coll_wrap |=> !coll_wrap);

    // R1: the final-byte marker only accompanies an offered byte
    a_r1_last_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
endmodule

bind rx_status_trailer rx_status_trailer_chk u_chk (
    .clk, .rst, .out_valid, .out_ready, .out_data, .out_last, .runt_wrap, .coll_wrap
);

// File: tb/rx_status_trailer_test.sv
module rx_status_trailer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DDEPTH     = 16;
    localparam int SDEPTH     = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic       in_coll = 1'b0, in_frame_err = 1'b0, in_fcs_err = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid, out_last, out_ready, runt_wrap, coll_wrap;
    logic [7:0] out_data;

    rx_status_trailer #(.DATA_DEPTH(DDEPTH), .STAT_DEPTH(SDEPTH)) uut (
        .clk, .rst, .in_valid, .in_data, .in_sof, .in_eof, .in_coll,
        .in_frame_err, .in_fcs_err, .out_valid, .out_data, .out_last,
        .out_ready, .runt_wrap, .coll_wrap
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    logic [7:0] runt_m = 0, coll_m = 0;
    int exp_runt_wraps = 0, exp_coll_wraps = 0;
    int got_runt_wraps = 0, got_coll_wraps = 0;

    int ready_mode = 0;

    function automatic logic [7:0] vbyte(int fid, int i);
        return 8'((fid * 7 + i * 3 + 1) & 255);
    endfunction

    task automatic check(bit ok, string req, int act, int exp, string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // expected model: stored bytes then trailer
    task automatic expect_frame(int fid, int len, int stored, bit ovf,
                                bit coll, bit fram, bit fcs);
        int cnt;
        logic [7:0] b1;
        cnt = (len > 4095) ? 4095 : len;
        for (int i = 0; i < stored; i++) begin
            exp_q.push_back({1'b0, vbyte(fid, i)});
            tag_q.push_back(ovf ? "R9" : "R1");
        end
        if (cnt < 64) begin
            if (runt_m == 8'hFF) exp_runt_wraps++;
            runt_m = runt_m + 1;
        end
        if (coll) begin
            if (coll_m == 8'hFF) exp_coll_wraps++;
            coll_m = coll_m + 1;
        end
        b1 = {ovf, coll, fram, fcs, 4'(cnt >> 8)};
        exp_q.push_back({1'b0, 8'(cnt & 255)});
        tag_q.push_back(len >= 4095 ? "R3" : "R2");
        exp_q.push_back({1'b0, b1});
        tag_q.push_back("R4");
        exp_q.push_back({1'b0, runt_m});
        tag_q.push_back("R5");
        exp_q.push_back({1'b1, coll_m});
        tag_q.push_back("R6");
    endtask

    task automatic send_frame(int fid, int len, bit coll, bit fram, bit fcs, int gap);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            in_valid     = 1'b1;
            in_sof       = (i == 0);
            in_eof       = (i == len - 1);
            in_data      = vbyte(fid, i);
            in_coll      = coll;
            in_frame_err = fram;
            in_fcs_err   = fcs;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (gap) @(posedge clk);
    endtask

    task automatic wait_drain();
        for (int k = 0; k < 20000 && exp_q.size() != 0; k++) @(posedge clk);
        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "R1", exp_q.size(), 0, "pending expected bytes");
    endtask

    // sink readiness
    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'b0;
            default: out_ready = (cycles % 3) != 0;
        endcase
    end

    // collector and pulse monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (runt_wrap) got_runt_wraps++;
            if (coll_wrap) got_coll_wraps++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", {out_last, out_data}, 0, "unexpected output byte");
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_last, out_data} == e, t, {out_last, out_data}, e, "output byte {last,data}");
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired: actual %0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        int fid;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12: idle outputs after reset
        check(out_valid == 1'b0, "R12", out_valid, 0, "out_valid after reset");
        check(runt_wrap == 1'b0, "R12", runt_wrap, 0, "runt_wrap after reset");
        check(coll_wrap == 1'b0, "R12", coll_wrap, 0, "coll_wrap after reset");

        // R11: stray bytes outside a frame
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 8'hA5;
        @(posedge clk); #1;
        in_eof = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0; in_eof = 1'b0;
        repeat (6) @(posedge clk);

        // R2 R4 R5 R6: length sweep 1..70 with flag patterns, free-running sink
        fid = 0;
        for (int len = 1; len <= 70; len++) begin
            fid++;
            expect_frame(fid, len, len, 1'b0, len[0], len[1], len[2]);
            send_frame(fid, len, len[0], len[1], len[2], 2);
            wait_drain();
        end

        // R8: throttled sink, frames fit the buffer
        ready_mode = 2;
        for (int len = 1; len <= DDEPTH; len++) begin
            fid++;
            expect_frame(fid, len, len, 1'b0, len[1], 1'b0, len[0]);
            send_frame(fid, len, len[1], 1'b0, len[0], 1);
            wait_drain();
        end
        ready_mode = 0;

        // R9: data buffer overflow with the sink held off
        ready_mode = 1;
        repeat (2) @(posedge clk);
        fid++;
        expect_frame(fid, 20, DDEPTH, 1'b1, 1'b0, 1'b0, 1'b1);
        send_frame(fid, 20, 1'b0, 1'b0, 1'b1, 2);
        ready_mode = 0;
        wait_drain();

        // R10: status queue full, fifth frame ignored
        ready_mode = 1;
        repeat (2) @(posedge clk);
        for (int f = 0; f < 5; f++) begin
            fid++;
            if (f < SDEPTH) expect_frame(fid, 2, 2, 1'b0, 1'b1, 1'b0, 1'b0);
            send_frame(fid, 2, 1'b1, 1'b0, 1'b0, 1);
        end
        ready_mode = 0;
        wait_drain();
        // R10: counters unaffected by the ignored frame, seen in next trailer
        fid++;
        expect_frame(fid, 3, 3, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(fid, 3, 1'b0, 1'b0, 1'b0, 2);
        wait_drain();

        // R5 R6 R7: push both counters through a wrap
        for (int f = 0; f < 260; f++) begin
            fid++;
            expect_frame(fid, 1 + (f % 3), 1 + (f % 3), 1'b0, 1'b1, 1'b0, 1'b0);
            send_frame(fid, 1 + (f % 3), 1'b1, 1'b0, 1'b0, 1);
            wait_drain();
        end
        check(got_runt_wraps == exp_runt_wraps, "R7", got_runt_wraps, exp_runt_wraps, "runt_wrap pulses");
        check(got_coll_wraps == exp_coll_wraps, "R7", got_coll_wraps, exp_coll_wraps, "coll_wrap pulses");
        check(exp_runt_wraps == 1, "R7", exp_runt_wraps, 1, "model runt wraps reached");

        // R3: count saturation
        fid++;
        expect_frame(fid, 4095, 4095, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(fid, 4095, 1'b0, 1'b0, 1'b0, 2);
        wait_drain();
        fid++;
        expect_frame(fid, 4096, 4096, 1'b0, 1'b0, 1'b1, 1'b0);
        send_frame(fid, 4096, 1'b0, 1'b1, 1'b0, 2);
        wait_drain();
        fid++;
        expect_frame(fid, 4100, 4100, 1'b0, 1'b1, 1'b0, 1'b0);
        send_frame(fid, 4100, 1'b1, 1'b0, 1'b0, 2);
        wait_drain();

        check(got_runt_wraps == exp_runt_wraps, "R7", got_runt_wraps, exp_runt_wraps, "final runt_wrap pulses");
        check(got_coll_wraps == exp_coll_wraps, "R7", got_coll_wraps, exp_coll_wraps, "final coll_wrap pulses");
        finish_run();
    end
endmodule